// File: doc/BRIEF.md
# Bus Mastership Arbitration Controller

This block sits in a processor's bus interface and decides when the processor hands its external bus to another master. Other devices share one active-low request line through a wired-OR. The processor always gives way to them, but only at a safe point. It waits for the operand transfer in progress to finish. It never yields inside a locked read-modify-write sequence. It never yields at all when the 2-bit show-cycle mode is set to the value that forbids external masters.

Both the request line and the grant-acknowledge line pass through a synchronizer before a registered state machine sees them, so every reaction comes a fixed number of clocks after the input changes. A requester that lets go before it acknowledges leaves the processor as master. A requester that acknowledges owns the bus until it releases the acknowledge. While the bus is granted or owned by another master, the block raises a hold signal so the cycle engine starts no new cycle. If the request line is still low while an external master holds the bus, that is taken as a second requester, and a fresh grant follows once the current tenure ends.

Top module: `bus_yield_arbiter`

## Requirements
- R1: During reset and right after it, `grant_n` is high and `hold_cpu` is low.
- R2: With nothing blocking, `grant_n` goes low exactly SYNC_STAGES+2 clocks after `ext_req_n` is first presented low, and not earlier.
- R3: If `ext_req_n` returns high before any acknowledge, `grant_n` returns high SYNC_STAGES+1 clocks later and `hold_cpu` is low, so the processor stays master.
- R4: An operand is open from a `cyc_start` pulse until a clock with both `cyc_end` and `last_cyc` high. No grant is given while an operand is open or in a clock where `cyc_start` is high. After the closing clock, the grant follows one clock later.
- R5: No grant is given while `rmw_lock` is high. Once it falls with a request pending, the grant follows one clock later.
- R6: While `show_mode` equals 2'b01, no grant is given. The values 2'b00, 2'b10 and 2'b11 do not block.
- R7: When `grant_ack_n` goes low during a grant, `grant_n` goes high and `hold_cpu` is high SYNC_STAGES+1 clocks later. `hold_cpu` stays high until SYNC_STAGES+1 clocks after `grant_ack_n` returns high, and then falls.
- R8: If `ext_req_n` is still low while an external master holds the bus, a new grant comes SYNC_STAGES+2 clocks after `grant_ack_n` returns high. If the request was released, no new grant comes.
- R9: `hold_cpu` is high in every clock in which `grant_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_req_n | input | 1 | Shared external bus request, active low, asynchronous |
| grant_ack_n | input | 1 | Grant acknowledge from the external master, active low, asynchronous |
| cyc_start | input | 1 | Processor bus cycle begins in this clock |
| cyc_end | input | 1 | Processor bus cycle terminates in this clock |
| last_cyc | input | 1 | The terminating cycle is the last of its operand |
| rmw_lock | input | 1 | Locked read-modify-write sequence in progress |
| show_mode | input | SHOW_W | Show-cycle mode field; value SHOW_BLOCK forbids granting |
| grant_n | output | 1 | Bus grant, active low, registered |
| hold_cpu | output | 1 | Keeps the processor from starting new bus cycles |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer, a 2-bit show-cycle field and 2'b01 as the blocking mode. With these values every latency is a short fixed count: a grant comes four clocks after a request, and a withdrawal or acknowledge takes effect after three. The bench can therefore check each edge in its exact clock and confirm that it did not come one clock early. All four show-mode values and their mixes with the lock are within reach in a handful of cycles. So are the one-clock handover at the close of an operand and the release of a lock.

// File: rtl/yield_pkg.sv
// Shared types for the bus mastership arbiter.
// Assumes: one state encoding used by the state machine and nothing else.
package yield_pkg;

    // Ownership states of the arbiter.
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,  // processor owns the bus, no request seen
        ST_WAIT_END  = 3'd1,  // request seen, waiting for a safe point
        ST_GRANTED   = 3'd2,  // grant driven, waiting for acknowledge
        ST_EXT_OWNER = 3'd3,  // external master owns the bus
        ST_REARM     = 3'd4   // external tenure with a second requester noted
    } own_state_e;

endpackage

// File: rtl/yield_sync.sv
// Multi-bit flop-chain synchronizer for asynchronous control inputs.
// Assumes: every bit is a level signal that is independent of the others;
// on reset the chain fills with RST_VAL (the inactive level).
module yield_sync #(
    parameter int                WIDTH   = 2,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage captures the raw asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[g] <= RST_VAL;
                    else        pipe[g] <= d;
                end
            end else begin : g_next
                // Later stages settle metastability one clock at a time.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[g] <= RST_VAL;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/yield_gate.sv
// Grant-blocking rules: tracks whether an operand transfer is open and
// combines that with the lock and show-cycle mode into one permission.
// Assumes: cyc_start, cyc_end, last_cyc and rmw_lock are synchronous to clk.
module yield_gate #(
    parameter int               SHOW_W     = 2,
    parameter logic [SHOW_W-1:0] SHOW_BLOCK = 2'b01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic              cyc_end,
    input  logic              last_cyc,
    input  logic              rmw_lock,
    input  logic [SHOW_W-1:0] show_mode,
    output logic              op_open,
    output logic              allow
);

    logic op_close;
    logic show_blocks;

    assign op_close    = cyc_end && last_cyc;
    assign show_blocks = (show_mode == SHOW_BLOCK);

    // Operand tracker: opens on a cycle start, closes on its last cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n)        op_open <= 1'b0;
        else if (op_close) op_open <= 1'b0;
        else if (cyc_start) op_open <= 1'b1;
    end

    // Permission: no open operand, no cycle starting now, no lock, no blocking mode.
    always_comb begin
        allow = !op_open && !cyc_start && !rmw_lock && !show_blocks;
    end

endmodule

// File: rtl/yield_fsm.sv
// Ownership state machine: turns a synchronized request and acknowledge
// plus the permission from the gate into a registered grant and a hold.
// Assumes: req_s and ack_s are active high and already synchronized.
module yield_fsm
    import yield_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic ack_s,
    input  logic allow,
    output logic grant_n,
    output logic hold_cpu
);

    own_state_e state_q, state_d;

    // Next-state selection for the ownership states.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_s) state_d = ST_WAIT_END;
            ST_WAIT_END:  begin
                if (!req_s)     state_d = ST_IDLE;
                else if (allow) state_d = ST_GRANTED;
            end
            ST_GRANTED:   begin
                if (ack_s)       state_d = ST_EXT_OWNER;
                else if (!req_s) state_d = ST_IDLE;
            end
            ST_EXT_OWNER: begin
                if (!ack_s)     state_d = ST_IDLE;
                else if (req_s) state_d = ST_REARM;
            end
            ST_REARM:     begin
                if (!ack_s) state_d = req_s ? ST_WAIT_END : ST_IDLE;
            end
            default:      state_d = ST_IDLE;
        endcase
    end

    // State and grant registers; grant is low only in the granted state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            grant_n <= 1'b1;
        end else begin
            state_q <= state_d;
            grant_n <= (state_d != ST_GRANTED);
        end
    end

    // Hold the cycle engine while the bus is offered or owned externally.
    always_comb begin
        hold_cpu = (state_q == ST_GRANTED) || (state_q == ST_EXT_OWNER) ||
                   (state_q == ST_REARM);
    end

    // R3: a grant only ever begins while a request was present.
    p_grant_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant_n) |-> $past(req_s));

    // R7: an acknowledged grant is never still driven a clock later.
    p_ack_drops_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_n && ack_s) |=> grant_n);

endmodule

// File: rtl/bus_yield_arbiter.sv
// Bus mastership arbitration controller: synchronizes the shared request
// and acknowledge inputs, applies the grant-blocking rules, and runs the
// ownership state machine that drives grant and the processor hold.
// Assumes: processor-side status inputs are synchronous to clk.
module bus_yield_arbiter #(
    parameter int                SYNC_STAGES = 2,
    parameter int                SHOW_W      = 2,
    parameter logic [SHOW_W-1:0] SHOW_BLOCK  = 2'b01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_req_n,
    input  logic              grant_ack_n,
    input  logic              cyc_start,
    input  logic              cyc_end,
    input  logic              last_cyc,
    input  logic              rmw_lock,
    input  logic [SHOW_W-1:0] show_mode,
    output logic              grant_n,
    output logic              hold_cpu
);

    localparam int SYNC_W = 2;

    logic [SYNC_W-1:0] raw_n, sync_n;
    logic              req_s, ack_s;
    logic              op_open, allow;

    assign raw_n = {grant_ack_n, ext_req_n};
    assign req_s = !sync_n[0];
    assign ack_s = !sync_n[1];

    yield_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('1)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_n),
        .q     (sync_n)
    );

    yield_gate #(
        .SHOW_W     (SHOW_W),
        .SHOW_BLOCK (SHOW_BLOCK)
    ) gate_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .cyc_end   (cyc_end),
        .last_cyc  (last_cyc),
        .rmw_lock  (rmw_lock),
        .show_mode (show_mode),
        .op_open   (op_open),
        .allow     (allow)
    );

    yield_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_s    (req_s),
        .ack_s    (ack_s),
        .allow    (allow),
        .grant_n  (grant_n),
        .hold_cpu (hold_cpu)
    );

    // R4: a grant never starts while an operand was open.
    p_no_grant_mid_operand_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant_n) |-> !$past(op_open));

    // R5: a grant never starts while the lock was asserted.
    p_no_grant_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant_n) |-> !$past(rmw_lock));

    // R6: a grant never starts while the blocking show mode was set.
    p_no_grant_show_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant_n) |-> ($past(show_mode) != SHOW_BLOCK));

    // R9: the processor is held whenever grant is driven.
    p_hold_while_granted_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_n |-> hold_cpu);

endmodule

// File: tb/bus_yield_arbiter_tb_top.sv
module bus_yield_arbiter_tb_top;

    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_req_n = 1'b1;
    logic       grant_ack_n = 1'b1;
    logic       cyc_start = 1'b0;
    logic       cyc_end = 1'b0;
    logic       last_cyc = 1'b0;
    logic       rmw_lock = 1'b0;
    logic [1:0] show_mode = 2'b00;
    logic       grant_n;
    logic       hold_cpu;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    // Vector bits: [3] lock, [2:1] show mode, [0] grant expected.
    localparam logic [3:0] VEC [6] = '{4'b0001, 4'b1000, 4'b0010,
                                       4'b0101, 4'b0111, 4'b1010};

    always #2 clk = ~clk;

    bus_yield_arbiter #(.SYNC_STAGES(SYNC)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n),
        .grant_ack_n(grant_ack_n), .cyc_start(cyc_start), .cyc_end(cyc_end),
        .last_cyc(last_cyc), .rmw_lock(rmw_lock), .show_mode(show_mode),
        .grant_n(grant_n), .hold_cpu(hold_cpu)
    );

    task automatic chk(input string req, input string what,
                       input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        chk("R1", "grant in reset", grant_n, 1'b1);
        chk("R1", "hold in reset", hold_cpu, 1'b0);
        rst_n = 1'b1;
        wait_n(2);
        chk("R1", "grant after reset", grant_n, 1'b1);
        chk("R1", "hold after reset", hold_cpu, 1'b0);

        // Table walk: R2, R3, R5, R6 over lock and show-mode mixes.
        foreach (VEC[i]) begin
            rmw_lock  = VEC[i][3];
            show_mode = VEC[i][2:1];
            ext_req_n = 1'b0;
            wait_n(SYNC + 1);
            chk("R2", "no early grant", grant_n, 1'b1);
            wait_n(1);
            chk(VEC[i][0] ? "R2" : "R5/R6", "grant at latency", grant_n, !VEC[i][0]);
            chk("R9", "hold with grant", hold_cpu, VEC[i][0]);
            ext_req_n = 1'b1;
            wait_n(SYNC + 1);
            chk("R3", "grant withdrawn", grant_n, 1'b1);
            chk("R3", "processor master", hold_cpu, 1'b0);
            rmw_lock  = 1'b0;
            show_mode = 2'b00;
            wait_n(3);
        end

        // R4: multi-cycle operand holds off the grant until its last cycle.
        cyc_start = 1'b1;
        wait_n(1);
        cyc_start = 1'b0;
        ext_req_n = 1'b0;
        wait_n(6);
        chk("R4", "blocked mid operand", grant_n, 1'b1);
        cyc_end = 1'b1;
        wait_n(1);
        cyc_end = 1'b0;
        wait_n(3);
        chk("R4", "blocked after non-last end", grant_n, 1'b1);
        cyc_end  = 1'b1;
        last_cyc = 1'b1;
        wait_n(1);
        cyc_end  = 1'b0;
        last_cyc = 1'b0;
        chk("R4", "not in closing clock", grant_n, 1'b1);
        wait_n(1);
        chk("R4", "grant after last cycle", grant_n, 1'b0);
        ext_req_n = 1'b1;
        wait_n(SYNC + 3);

        // R5: lock held then released with a request pending.
        rmw_lock  = 1'b1;
        ext_req_n = 1'b0;
        wait_n(6);
        chk("R5", "blocked while locked", grant_n, 1'b1);
        rmw_lock = 1'b0;
        wait_n(1);
        chk("R5", "grant after unlock", grant_n, 1'b0);
        ext_req_n = 1'b1;
        wait_n(SYNC + 3);

        // R7/R8: acknowledged tenure with a second requester still asserting.
        ext_req_n = 1'b0;
        wait_n(SYNC + 2);
        chk("R2", "grant before tenure", grant_n, 1'b0);
        grant_ack_n = 1'b0;
        wait_n(SYNC);
        chk("R7", "grant kept until ack synced", grant_n, 1'b0);
        wait_n(1);
        chk("R7", "grant dropped on ack", grant_n, 1'b1);
        chk("R7", "hold in tenure", hold_cpu, 1'b1);
        wait_n(5);
        chk("R7", "hold stays in tenure", hold_cpu, 1'b1);
        chk("R8", "no grant in tenure", grant_n, 1'b1);
        grant_ack_n = 1'b1;
        wait_n(SYNC);
        chk("R7", "hold until release synced", hold_cpu, 1'b1);
        wait_n(1);
        chk("R7", "hold falls after release", hold_cpu, 1'b0);
        chk("R8", "no grant yet", grant_n, 1'b1);
        wait_n(1);
        chk("R8", "rearmed grant", grant_n, 1'b0);

        // R7/R8: single tenure, request released with the acknowledge.
        grant_ack_n = 1'b0;
        ext_req_n   = 1'b1;
        wait_n(SYNC + 1);
        chk("R7", "grant dropped, single", grant_n, 1'b1);
        chk("R7", "hold, single", hold_cpu, 1'b1);
        wait_n(3);
        chk("R7", "tenure kept without request", hold_cpu, 1'b1);
        grant_ack_n = 1'b1;
        wait_n(SYNC + 1);
        chk("R7", "hold released, single", hold_cpu, 1'b0);
        wait_n(5);
        chk("R8", "no rearm without request", grant_n, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule